// File: doc/BRIEF.md
# Sticky Fatal Error Code Register

This block gathers the fatal fault indications of an entropy-distribution controller into one 32-bit error code. Each bit latches the first time its source fires and holds until reset. Fault sources are two command queues, two state machines and a hardened counter. For the queues, the block records which queue failed separately from how it failed: an overflow write, an underflow read, or a status where full and empty are both asserted.

A forcing port lets software name a bit index and inject a single error pulse there. This proves that each bit reaches the interrupt and alert outputs. The block also holds a two-bit interrupt state set, with an enable register and a force register beside it. The done event and the fatal indication each drive an interrupt line. A continuous fatal alert level goes to the external alert handler.

Top module: `fatal_err_code`

## Requirements
- R1: After reset the error code, interrupt state and interrupt enable are all zero, and the done interrupt, fatal interrupt and fatal alert outputs are low.
- R2: Any error of any kind on queue k (k=0 is the reseed queue, k=1 the generate queue) sets error code bit k on the clock edge that samples it.
- R3: The error type bits are set on the same edge as the queue bit. An overflow write sets bit 28. An underflow read sets bit 29. Full and empty together set bit 30. A counter error sets both bit 22 and bit 30.
- R4: An illegal state in the acknowledge state machine sets bit 20. An illegal state in the main state machine sets bit 21.
- R5: Every error code bit, once set, stays set until reset. No input clears it. Bits other than 0, 1, 20, 21, 22, 28, 29 and 30 always read zero.
- R6: A force write with a 5-bit index naming one of the defined bits sets exactly that bit on the next edge, and sets no type or companion bit with it.
- R7: A force write whose index names a reserved bit changes nothing in the error code.
- R8: Interrupt state bit 0 (done) is set by the done event. Writing 1 to a state bit clears it, and a set arriving on the same edge wins over the clear. A force write of 1 sets the corresponding state bit.
- R9: Each interrupt output equals its state bit ANDed with its enable bit. The enable bits are loaded by an enable write.
- R10: While any error code bit is set, interrupt state bit 1 (fatal) reads 1 even after a write-1-to-clear, and the fatal alert output is high. With no error latched, a forced fatal state bit can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_wr_err_i | input | NUM_FIFO | Per-queue overflow write pulse |
| fifo_rd_err_i | input | NUM_FIFO | Per-queue underflow read pulse |
| fifo_both_err_i | input | NUM_FIFO | Per-queue full-and-empty status pulse |
| ack_fsm_err_i | input | 1 | Acknowledge state machine illegal state |
| main_fsm_err_i | input | 1 | Main state machine illegal state |
| cnt_err_i | input | 1 | Hardened counter fault |
| force_we_i | input | 1 | Force write strobe |
| force_idx_i | input | 5 | Bit index to force |
| cmd_done_i | input | 1 | Command completion event |
| irq_clr_we_i | input | 1 | Interrupt state write-1-to-clear strobe |
| irq_clr_i | input | 2 | Interrupt state clear mask |
| irq_en_we_i | input | 1 | Interrupt enable write strobe |
| irq_en_i | input | 2 | Interrupt enable value |
| irq_force_we_i | input | 1 | Interrupt force write strobe |
| irq_force_i | input | 2 | Interrupt force mask |
| err_code_o | output | 32 | Sticky error code |
| irq_state_o | output | 2 | Interrupt state (bit 0 done, bit 1 fatal) |
| irq_enable_o | output | 2 | Interrupt enable |
| irq_done_o | output | 1 | Done interrupt line |
| irq_fatal_o | output | 1 | Fatal interrupt line |
| fatal_alert_o | output | 1 | Fatal alert level |

## Verification
The bench uses the default parameters: two queues, a 32-bit code and a 5-bit force index. With these values both queue bits and every type bit can be reached. The 5-bit index also covers all 32 positions, so random force writes regularly land on reserved indices as well as defined ones. Repeated reset episodes with sparse random faults give each episode a different first fault and a different combination of latched bits. Directed steps cover set-versus-clear collisions and fatal clears that the latched error blocks.

// File: rtl/ferr_pkg.sv
package ferr_pkg;
    localparam int unsigned CODE_W   = 32;
    localparam int unsigned IDX_W    = $clog2(CODE_W);
    localparam int unsigned NUM_IRQ  = 2;
    localparam int unsigned IRQ_DONE  = 0;
    localparam int unsigned IRQ_FATAL = 1;

    localparam int unsigned BIT_ACK_FSM  = 20;
    localparam int unsigned BIT_MAIN_FSM = 21;
    localparam int unsigned BIT_CNT      = 22;
    localparam int unsigned BIT_WR       = 28;
    localparam int unsigned BIT_RD       = 29;
    localparam int unsigned BIT_BOTH     = 30;

    function automatic logic [CODE_W-1:0] valid_mask(input int unsigned nf);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < nf; k++) m[k] = 1'b1;
        m[BIT_ACK_FSM]  = 1'b1;
        m[BIT_MAIN_FSM] = 1'b1;
        m[BIT_CNT]      = 1'b1;
        m[BIT_WR]       = 1'b1;
        m[BIT_RD]       = 1'b1;
        m[BIT_BOTH]     = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } sticky_t;

    typedef struct packed {
        logic [NUM_IRQ-1:0] st;
        logic [NUM_IRQ-1:0] en;
    } irq_regs_t;
endpackage

// File: rtl/ferr_src_map.sv
module ferr_src_map
    import ferr_pkg::*;
#(
    parameter int unsigned NUM_FIFO = 2
) (
    input  logic [NUM_FIFO-1:0] wr_err_i,
    input  logic [NUM_FIFO-1:0] rd_err_i,
    input  logic [NUM_FIFO-1:0] both_err_i,
    input  logic                ack_err_i,
    input  logic                main_err_i,
    input  logic                cnt_err_i,
    output logic [CODE_W-1:0]   evt_o
);
    logic [NUM_FIFO-1:0] any_fifo;

    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo
        assign any_fifo[k] = wr_err_i[k] | rd_err_i[k] | both_err_i[k];
    end

    always_comb begin
        evt_o = '0;
        evt_o[NUM_FIFO-1:0] = any_fifo;
        evt_o[BIT_ACK_FSM]  = ack_err_i;
        evt_o[BIT_MAIN_FSM] = main_err_i;
        evt_o[BIT_CNT]      = cnt_err_i;
        evt_o[BIT_WR]       = |wr_err_i;
        evt_o[BIT_RD]       = |rd_err_i;
        evt_o[BIT_BOTH]     = (|both_err_i) | cnt_err_i;
    end
endmodule

// File: rtl/ferr_force_dec.sv
module ferr_force_dec
    import ferr_pkg::*;
#(
    parameter int unsigned NUM_FIFO = 2
) (
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] pulse_o
);
    localparam logic [CODE_W-1:0] MASK = valid_mask(NUM_FIFO);

    logic [CODE_W-1:0] onehot;

    always_comb begin
        onehot = '0;
        onehot[idx_i] = we_i;
        pulse_o = onehot & MASK;
    end
endmodule

// File: rtl/ferr_sticky.sv
module ferr_sticky
    import ferr_pkg::*;
#(
    parameter int unsigned NUM_FIFO = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] evt_i,
    input  logic [CODE_W-1:0] force_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_next_o
);
    localparam logic [CODE_W-1:0] MASK = valid_mask(NUM_FIFO);

    sticky_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.code = s_q.code | ((evt_i | force_i) & MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign code_o     = s_q.code;
    assign any_next_o = |s_d.code;

    for (genvar i = 0; i < CODE_W; i++) begin : g_hold
        a_r5_bit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            s_q.code[i] |=> s_q.code[i]);
    end

    a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.code & ~MASK) == '0);
endmodule

// File: rtl/ferr_irq.sv
module ferr_irq
    import ferr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic               clr_we_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    input  logic               en_we_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic               frc_we_i,
    input  logic [NUM_IRQ-1:0] frc_i,
    output logic [NUM_IRQ-1:0] state_o,
    output logic [NUM_IRQ-1:0] enable_o,
    output logic [NUM_IRQ-1:0] irq_o
);
    irq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int j = 0; j < NUM_IRQ; j++) begin
            r_d.st[j] = set_i[j] | (frc_we_i & frc_i[j]) |
                        (r_q.st[j] & ~(clr_we_i & clr_i[j]));
        end
        if (en_we_i) r_d.en = en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign state_o  = r_q.st;
    assign enable_o = r_q.en;

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_line
        assign irq_o[j] = r_q.st[j] & r_q.en[j];

        a_r8_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (frc_we_i && frc_i[j]) |=> r_q.st[j]);
        a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[j] |=> r_q.st[j]);
    end
endmodule

// File: rtl/fatal_err_code.sv
module fatal_err_code
    import ferr_pkg::*;
#(
    parameter int unsigned NUM_FIFO = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_FIFO-1:0] fifo_wr_err_i,
    input  logic [NUM_FIFO-1:0] fifo_rd_err_i,
    input  logic [NUM_FIFO-1:0] fifo_both_err_i,
    input  logic                ack_fsm_err_i,
    input  logic                main_fsm_err_i,
    input  logic                cnt_err_i,
    input  logic                force_we_i,
    input  logic [IDX_W-1:0]    force_idx_i,
    input  logic                cmd_done_i,
    input  logic                irq_clr_we_i,
    input  logic [NUM_IRQ-1:0]  irq_clr_i,
    input  logic                irq_en_we_i,
    input  logic [NUM_IRQ-1:0]  irq_en_i,
    input  logic                irq_force_we_i,
    input  logic [NUM_IRQ-1:0]  irq_force_i,
    output logic [CODE_W-1:0]   err_code_o,
    output logic [NUM_IRQ-1:0]  irq_state_o,
    output logic [NUM_IRQ-1:0]  irq_enable_o,
    output logic                irq_done_o,
    output logic                irq_fatal_o,
    output logic                fatal_alert_o
);
    logic [CODE_W-1:0]  evt;
    logic [CODE_W-1:0]  frc;
    logic               any_next;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] irq_lines;

    ferr_src_map #(.NUM_FIFO(NUM_FIFO)) u_map (
        .wr_err_i   (fifo_wr_err_i),
        .rd_err_i   (fifo_rd_err_i),
        .both_err_i (fifo_both_err_i),
        .ack_err_i  (ack_fsm_err_i),
        .main_err_i (main_fsm_err_i),
        .cnt_err_i  (cnt_err_i),
        .evt_o      (evt)
    );

    ferr_force_dec #(.NUM_FIFO(NUM_FIFO)) u_dec (
        .we_i    (force_we_i),
        .idx_i   (force_idx_i),
        .pulse_o (frc)
    );

    ferr_sticky #(.NUM_FIFO(NUM_FIFO)) u_sticky (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt),
        .force_i    (frc),
        .code_o     (err_code_o),
        .any_next_o (any_next)
    );

    always_comb begin
        irq_set = '0;
        irq_set[IRQ_DONE]  = cmd_done_i;
        irq_set[IRQ_FATAL] = any_next;
    end

    ferr_irq u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (irq_set),
        .clr_we_i (irq_clr_we_i),
        .clr_i    (irq_clr_i),
        .en_we_i  (irq_en_we_i),
        .en_i     (irq_en_i),
        .frc_we_i (irq_force_we_i),
        .frc_i    (irq_force_i),
        .state_o  (irq_state_o),
        .enable_o (irq_enable_o),
        .irq_o    (irq_lines)
    );

    assign irq_done_o    = irq_lines[IRQ_DONE];
    assign irq_fatal_o   = irq_lines[IRQ_FATAL];
    assign fatal_alert_o = |err_code_o;

    a_r10_fatal_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|err_code_o) |-> irq_state_o[IRQ_FATAL]);
    a_r3_wr_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fifo_wr_err_i) |=> err_code_o[BIT_WR]);
    a_r3_cnt_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_err_i |=> (err_code_o[BIT_CNT] && err_code_o[BIT_BOTH]));
    a_r4_main_fsm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_fsm_err_i |=> err_code_o[BIT_MAIN_FSM]);
    a_r6_force_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_we_i && force_idx_i == IDX_W'(BIT_CNT)) |=> err_code_o[BIT_CNT]);
    a_r2_fifo0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_rd_err_i[0] || fifo_wr_err_i[0] || fifo_both_err_i[0]) |=> err_code_o[0]);
endmodule

// File: tb/sim_fatal_err_code.sv
`timescale 1ns/1ps
module sim_fatal_err_code;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_e = '0, rd_e = '0, bo_e = '0;
    logic        ack_e = 1'b0, main_e = 1'b0, cnt_e = 1'b0;
    logic        f_we = 1'b0;
    logic [4:0]  f_idx = '0;
    logic        done = 1'b0;
    logic        c_we = 1'b0, e_we = 1'b0, t_we = 1'b0;
    logic [1:0]  c_v = '0, e_v = '0, t_v = '0;
    logic [31:0] code;
    logic [1:0]  st, en;
    logic        irq_d, irq_f, alert;

    int unsigned n_chk = 0, n_err = 0;
    logic [31:0] x_code;
    logic [1:0]  x_st, x_en;

    always #10 clk = ~clk;

    fatal_err_code u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .fifo_wr_err_i(wr_e), .fifo_rd_err_i(rd_e), .fifo_both_err_i(bo_e),
        .ack_fsm_err_i(ack_e), .main_fsm_err_i(main_e), .cnt_err_i(cnt_e),
        .force_we_i(f_we), .force_idx_i(f_idx), .cmd_done_i(done),
        .irq_clr_we_i(c_we), .irq_clr_i(c_v),
        .irq_en_we_i(e_we), .irq_en_i(e_v),
        .irq_force_we_i(t_we), .irq_force_i(t_v),
        .err_code_o(code), .irq_state_o(st), .irq_enable_o(en),
        .irq_done_o(irq_d), .irq_fatal_o(irq_f), .fatal_alert_o(alert)
    );

    function automatic logic is_defined(input logic [4:0] i);
        return i == 0 || i == 1 || i == 20 || i == 21 || i == 22 ||
               i == 28 || i == 29 || i == 30;
    endfunction

    function automatic logic [31:0] next_code(input logic [31:0] c);
        logic [31:0] n;
        n = c;
        if (wr_e[0] | rd_e[0] | bo_e[0]) n[0] = 1'b1;
        if (wr_e[1] | rd_e[1] | bo_e[1]) n[1] = 1'b1;
        if (|wr_e) n[28] = 1'b1;
        if (|rd_e) n[29] = 1'b1;
        if ((|bo_e) | cnt_e) n[30] = 1'b1;
        if (cnt_e)  n[22] = 1'b1;
        if (ack_e)  n[20] = 1'b1;
        if (main_e) n[21] = 1'b1;
        if (f_we && is_defined(f_idx)) n[f_idx] = 1'b1;
        return n;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "err_code", code, x_code);
        chk(tag, "irq_state", {30'd0, st}, {30'd0, x_st});
        chk(tag, "irq_enable", {30'd0, en}, {30'd0, x_en});
        chk(tag, "irq_done", {31'd0, irq_d}, {31'd0, x_st[0] & x_en[0]});
        chk(tag, "irq_fatal", {31'd0, irq_f}, {31'd0, x_st[1] & x_en[1]});
        chk(tag, "alert", {31'd0, alert}, {31'd0, |x_code});
    endtask

    task automatic idle_inputs();
        wr_e = '0; rd_e = '0; bo_e = '0; ack_e = 0; main_e = 0; cnt_e = 0;
        f_we = 0; done = 0; c_we = 0; e_we = 0; t_we = 0;
    endtask

    task automatic cyc(input string tag);
        logic [31:0] nc;
        logic [1:0]  ns, ne;
        nc = next_code(x_code);
        ns[0] = done | (t_we & t_v[0]) | (x_st[0] & ~(c_we & c_v[0]));
        ns[1] = (|nc) | (t_we & t_v[1]) | (x_st[1] & ~(c_we & c_v[1]));
        ne = e_we ? e_v : x_en;
        @(posedge clk);
        #1;
        x_code = nc; x_st = ns; x_en = ne;
        compare(tag);
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        x_code = '0; x_st = '0; x_en = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        compare("R1 reset");

        f_we = 1; f_idx = 5'd5;  cyc("R7 reserved idx 5");
        f_we = 1; f_idx = 5'd31; cyc("R7 reserved idx 31");
        f_we = 1; f_idx = 5'd2;  cyc("R7 reserved idx 2");

        wr_e = 2'b10; cyc("R2 R3 overflow on generate queue");
        repeat (3) cyc("R5 sticky idle");
        c_we = 1; c_v = 2'b10; cyc("R10 fatal clear blocked");
        e_we = 1; e_v = 2'b10; cyc("R9 fatal line enabled");

        do_reset();
        rd_e = 2'b01; cyc("R2 R3 underflow on reseed queue");
        do_reset();
        bo_e = 2'b10; cyc("R3 full and empty on generate queue");
        do_reset();
        cnt_e = 1; cyc("R3 counter sets 22 and 30");
        do_reset();
        ack_e = 1; cyc("R4 ack state machine");
        main_e = 1; cyc("R4 main state machine");

        do_reset();
        f_we = 1; f_idx = 5'd22; cyc("R6 force bit 22 alone");
        f_we = 1; f_idx = 5'd28; cyc("R6 force bit 28 alone");
        f_we = 1; f_idx = 5'd1;  cyc("R6 force bit 1 alone");

        do_reset();
        done = 1; cyc("R8 done sets state");
        cyc("R9 done line masked");
        e_we = 1; e_v = 2'b01; cyc("R9 done line enabled");
        c_we = 1; c_v = 2'b01; cyc("R8 clear done");
        done = 1; c_we = 1; c_v = 2'b01; cyc("R8 set wins over clear");
        t_we = 1; t_v = 2'b10; cyc("R8 force fatal state");
        c_we = 1; c_v = 2'b10; cyc("R10 forced fatal clears with no error");
        t_we = 1; t_v = 2'b01; c_we = 1; c_v = 2'b11; cyc("R8 force wins over clear");

        for (int ep = 0; ep < 40; ep++) begin
            do_reset();
            for (int c = 0; c < 40; c++) begin
                wr_e   = {($urandom % 25) == 0, ($urandom % 25) == 0};
                rd_e   = {($urandom % 25) == 0, ($urandom % 25) == 0};
                bo_e   = {($urandom % 25) == 0, ($urandom % 25) == 0};
                ack_e  = ($urandom % 40) == 0;
                main_e = ($urandom % 40) == 0;
                cnt_e  = ($urandom % 40) == 0;
                f_we   = ($urandom % 8) == 0;
                f_idx  = 5'($urandom);
                done   = ($urandom % 6) == 0;
                c_we   = ($urandom % 4) == 0;
                c_v    = 2'($urandom);
                e_we   = ($urandom % 5) == 0;
                e_v    = 2'($urandom);
                t_we   = ($urandom % 10) == 0;
                t_v    = 2'($urandom);
                cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule